// File: doc/BRIEF.md
# Host Mailbox with Doorbell Interrupts

This block is a small register file shared by a host processor and an on-chip service controller. Each side has its own register request port and its own read response. Together they reach eight 64-bit mailbox entries and two 64-bit doorbell registers, one doorbell for each direction. The mailbox is split by direction. The host fills the request half (entries 0 to 3) and the controller fills the response half (entries 4 to 7). Both sides can read every entry.

Each doorbell can be reached at three addresses. One is a plain read/write address. The second ANDs the written word into the register, which clears bits. The third ORs the written word into the register, which sets bits. Any set bit in a doorbell drives a level interrupt toward the side that receives it. That interrupt stays high until software clears every bit.

The request ports use a valid/ready handshake. The block never applies back-pressure: ready is held high, so every request with valid high is taken on that clock edge. A read answers with a one-cycle response-valid pulse on the next cycle. The response has no ready, so the requester must accept it in that cycle. Writes produce no response.

Top module: `host_mailbox`

## Requirements
- R1: After reset every mailbox entry and both doorbells read as zero, both interrupts are low, and no response is valid.
- R2: Request ready is always high. A read taken at a clock edge gives response-valid high for exactly the next cycle. The read data is the register value from before any write taken at that same edge. A write, or no request, gives response-valid low.
- R3: Addresses 0x50 to 0x57 select mailbox entries 0 to 7, and both sides read every entry.
- R4: Only the host can write entries 0 to 3 and only the controller can write entries 4 to 7. A write from the other side leaves the entry unchanged.
- R5: The doorbell toward the controller is read/write at 0x60, AND-write at 0x61 and OR-write at 0x62. The doorbell toward the host uses 0x63, 0x64 and 0x65 in the same roles.
- R6: Doorbell bits are numbered from the MSB, so bit 0 is 0x8000_0000_0000_0000 and bit 2 is 0x2000_0000_0000_0000. An AND-write of 0x7FFF_FFFF_FFFF_FFFF clears bit 0 only.
- R7: A read of an AND or OR alias returns the current doorbell value.
- R8: A read of any address outside 0x50 to 0x57 and 0x60 to 0x65 returns zero, and a write to such an address changes nothing.
- R9: The interrupt to the controller is high exactly when the doorbell toward the controller is non-zero. The interrupt to the host is high exactly when the doorbell toward the host is non-zero. Both change on the edge that updates the register.
- R10: When both sides write the same doorbell at the same edge, the updates apply in this order. A plain write comes first, and the controller's value wins if both sides write plainly. Every OR mask comes next, and every AND mask comes last. So a clear wins over a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request ready (always 1) |
| h_req_write | input | 1 | Host request is a write |
| h_req_addr | input | 8 | Host word address |
| h_req_wdata | input | 64 | Host write data |
| h_rsp_valid | output | 1 | Host read response valid |
| h_rsp_rdata | output | 64 | Host read response data |
| c_req_valid | input | 1 | Controller request valid |
| c_req_ready | output | 1 | Controller request ready (always 1) |
| c_req_write | input | 1 | Controller request is a write |
| c_req_addr | input | 8 | Controller word address |
| c_req_wdata | input | 64 | Controller write data |
| c_rsp_valid | output | 1 | Controller read response valid |
| c_rsp_rdata | output | 64 | Controller read response data |
| irq_ctl | output | 1 | Level interrupt to the controller |
| irq_host | output | 1 | Level interrupt to the host |

## Verification
The assertions check on every cycle the following behaviours:
- an OR mask always lands in the doorbell unless an AND write comes in the same cycle;
- an AND mask always removes its zero bits;
- an idle doorbell holds its value;
- a mailbox entry changes only when its owning side writes it;
- a response appears only after a read request;
- an interrupt rises only after a write request.

Only the bench scenarios can show the rest:
- the full address map, including unmapped holes and alias reads;
- the exact result of same-cycle collisions between the two sides;
- whether read data reflects the state before a write at the same edge.

// File: rtl/host_mbx_pkg.sv
package host_mbx_pkg;
  typedef enum logic [1:0] {
    DB_NONE = 2'd0,
    DB_RW   = 2'd1,
    DB_AND  = 2'd2,
    DB_OR   = 2'd3
  } db_op_e;
endpackage

// File: rtl/host_mbx_decode.sv
module host_mbx_decode
  import host_mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned MBOX_N    = 8,
  parameter int unsigned MBOX_BASE = 'h50,
  parameter int unsigned DB_BASE   = 'h60,
  localparam int unsigned IDX_W    = $clog2(MBOX_N)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              mb_hit,
  output logic [IDX_W-1:0]  mb_idx,
  output logic              db_hit,
  output logic              db_sel,
  output db_op_e            db_op
);
  localparam int unsigned DB_SPAN = 6;

  logic [31:0] a_w, mb_off, db_off;

  always_comb begin
    a_w    = 32'(addr);
    mb_off = a_w - 32'(MBOX_BASE);
    db_off = a_w - 32'(DB_BASE);
    mb_hit = (a_w >= 32'(MBOX_BASE)) && (mb_off < 32'(MBOX_N));
    mb_idx = IDX_W'(mb_off);
    db_hit = (a_w >= 32'(DB_BASE)) && (db_off < 32'(DB_SPAN));
    db_sel = db_off >= 32'd3;
    db_op  = DB_NONE;
    if (db_hit) begin
      case (db_off % 32'd3)
        32'd0:   db_op = DB_RW;
        32'd1:   db_op = DB_AND;
        default: db_op = DB_OR;
      endcase
    end
  end
endmodule

// File: rtl/host_mbx_doorbell.sv
module host_mbx_doorbell
  import host_mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  db_op_e            a_op,
  input  logic [DATA_W-1:0] a_data,
  input  db_op_e            b_op,
  input  logic [DATA_W-1:0] b_data,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] base, or_m, and_m, nxt;

  // plain write (b last, so it wins), then OR masks, then AND masks
  always_comb begin
    base = q;
    if (a_op == DB_RW) base = a_data;
    if (b_op == DB_RW) base = b_data;
    or_m  = (a_op == DB_OR ? a_data : '0) | (b_op == DB_OR ? b_data : '0);
    and_m = (a_op == DB_AND ? a_data : '1) & (b_op == DB_AND ? b_data : '1);
    nxt   = (base | or_m) & and_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assert_or_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_op == DB_OR && b_op != DB_AND) |=> ((q & $past(a_data)) == $past(a_data)));
  assert_and_clears_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_op == DB_AND) |=> ((q & ~$past(a_data)) == '0));
  assert_and_clears_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (b_op == DB_AND) |=> ((q & ~$past(b_data)) == '0));
  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_op == DB_NONE && b_op == DB_NONE) |=> $stable(q));
endmodule

// File: rtl/host_mbx_storage.sv
module host_mbx_storage #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned MBOX_N = 8,
  localparam int unsigned IDX_W = $clog2(MBOX_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic [IDX_W-1:0]  h_idx,
  input  logic [DATA_W-1:0] h_wd,
  input  logic              c_we,
  input  logic [IDX_W-1:0]  c_idx,
  input  logic [DATA_W-1:0] c_wd,
  output logic [DATA_W-1:0] mem_q [MBOX_N]
);
  localparam int unsigned HALF = MBOX_N / 2;

  for (genvar i = 0; i < MBOX_N; i++) begin : g_entry
    logic we;
    logic [DATA_W-1:0] wd;
    if (i < HALF) begin : g_req
      assign we = h_we && (h_idx == IDX_W'(i));
      assign wd = h_wd;
    end else begin : g_rsp
      assign we = c_we && (c_idx == IDX_W'(i));
      assign wd = c_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[i] <= '0;
      else if (we) mem_q[i] <= wd;
    end

    assert_owner_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(i < HALF ? (h_we && h_idx == IDX_W'(i)) : (c_we && c_idx == IDX_W'(i)))
      |=> $stable(mem_q[i]));
  end
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import host_mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned MBOX_N    = 8,
  parameter int unsigned MBOX_BASE = 'h50,
  parameter int unsigned DB_BASE   = 'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req_valid,
  output logic              h_req_ready,
  input  logic              h_req_write,
  input  logic [ADDR_W-1:0] h_req_addr,
  input  logic [DATA_W-1:0] h_req_wdata,
  output logic              h_rsp_valid,
  output logic [DATA_W-1:0] h_rsp_rdata,
  input  logic              c_req_valid,
  output logic              c_req_ready,
  input  logic              c_req_write,
  input  logic [ADDR_W-1:0] c_req_addr,
  input  logic [DATA_W-1:0] c_req_wdata,
  output logic              c_rsp_valid,
  output logic [DATA_W-1:0] c_rsp_rdata,
  output logic              irq_ctl,
  output logic              irq_host
);
  localparam int unsigned IDX_W = $clog2(MBOX_N);
  localparam int unsigned SIDES = 2;   // 0 = host, 1 = controller

  logic              s_valid [SIDES];
  logic              s_write [SIDES];
  logic [ADDR_W-1:0] s_addr  [SIDES];
  logic [DATA_W-1:0] s_wdata [SIDES];
  logic              mb_hit  [SIDES];
  logic [IDX_W-1:0]  mb_idx  [SIDES];
  logic              db_hit  [SIDES];
  logic              db_sel  [SIDES];
  db_op_e            db_op   [SIDES];
  logic [DATA_W-1:0] rd_val  [SIDES];
  logic              rsp_v   [SIDES];
  logic [DATA_W-1:0] rsp_d   [SIDES];
  logic [DATA_W-1:0] mem_q   [MBOX_N];
  logic [DATA_W-1:0] db_q    [2];      // 0 = toward controller, 1 = toward host

  assign s_valid[0] = h_req_valid;  assign s_valid[1] = c_req_valid;
  assign s_write[0] = h_req_write;  assign s_write[1] = c_req_write;
  assign s_addr[0]  = h_req_addr;   assign s_addr[1]  = c_req_addr;
  assign s_wdata[0] = h_req_wdata;  assign s_wdata[1] = c_req_wdata;

  assign h_req_ready = 1'b1;
  assign c_req_ready = 1'b1;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    host_mbx_decode #(
      .ADDR_W(ADDR_W), .MBOX_N(MBOX_N), .MBOX_BASE(MBOX_BASE), .DB_BASE(DB_BASE)
    ) i_dec (
      .addr(s_addr[s]), .mb_hit(mb_hit[s]), .mb_idx(mb_idx[s]),
      .db_hit(db_hit[s]), .db_sel(db_sel[s]), .db_op(db_op[s])
    );

    always_comb begin
      rd_val[s] = '0;
      if (mb_hit[s])      rd_val[s] = mem_q[mb_idx[s]];
      else if (db_hit[s]) rd_val[s] = db_q[db_sel[s]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rsp_v[s] <= 1'b0;
        rsp_d[s] <= '0;
      end else begin
        rsp_v[s] <= s_valid[s] && !s_write[s];
        if (s_valid[s] && !s_write[s]) rsp_d[s] <= rd_val[s];
      end
    end
  end

  assign h_rsp_valid = rsp_v[0];  assign h_rsp_rdata = rsp_d[0];
  assign c_rsp_valid = rsp_v[1];  assign c_rsp_rdata = rsp_d[1];

  host_mbx_storage #(.DATA_W(DATA_W), .MBOX_N(MBOX_N)) i_store (
    .clk(clk), .rst_n(rst_n),
    .h_we(s_valid[0] && s_write[0] && mb_hit[0]), .h_idx(mb_idx[0]), .h_wd(s_wdata[0]),
    .c_we(s_valid[1] && s_write[1] && mb_hit[1]), .c_idx(mb_idx[1]), .c_wd(s_wdata[1]),
    .mem_q(mem_q)
  );

  for (genvar d = 0; d < 2; d++) begin : g_db
    db_op_e op_a, op_b;
    assign op_a = (s_valid[0] && s_write[0] && db_hit[0] && db_sel[0] == d[0]) ? db_op[0] : DB_NONE;
    assign op_b = (s_valid[1] && s_write[1] && db_hit[1] && db_sel[1] == d[0]) ? db_op[1] : DB_NONE;

    host_mbx_doorbell #(.DATA_W(DATA_W)) i_bell (
      .clk(clk), .rst_n(rst_n),
      .a_op(op_a), .a_data(s_wdata[0]),
      .b_op(op_b), .b_data(s_wdata[1]),
      .q(db_q[d])
    );
  end

  assign irq_ctl  = |db_q[0];
  assign irq_host = |db_q[1];

  assert_h_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid |-> $past(h_req_valid && !h_req_write));
  assert_c_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_rsp_valid |-> $past(c_req_valid && !c_req_write));
  assert_irq_ctl_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ctl) |-> $past((h_req_valid && h_req_write) || (c_req_valid && c_req_write)));
  assert_irq_host_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_host) |-> $past((h_req_valid && h_req_write) || (c_req_valid && c_req_write)));
endmodule

// File: tb/test_host_mailbox.sv
`timescale 1ns/1ps
module test_host_mailbox;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        h_req_valid = 0, h_req_write = 0, c_req_valid = 0, c_req_write = 0;
  logic [7:0]  h_req_addr = 0, c_req_addr = 0;
  logic [63:0] h_req_wdata = 0, c_req_wdata = 0;
  logic        h_req_ready, c_req_ready, h_rsp_valid, c_rsp_valid, irq_ctl, irq_host;
  logic [63:0] h_rsp_rdata, c_rsp_rdata;

  host_mailbox i_host_mailbox (
    .clk(clk), .rst_n(rst_n),
    .h_req_valid(h_req_valid), .h_req_ready(h_req_ready), .h_req_write(h_req_write),
    .h_req_addr(h_req_addr), .h_req_wdata(h_req_wdata),
    .h_rsp_valid(h_rsp_valid), .h_rsp_rdata(h_rsp_rdata),
    .c_req_valid(c_req_valid), .c_req_ready(c_req_ready), .c_req_write(c_req_write),
    .c_req_addr(c_req_addr), .c_req_wdata(c_req_wdata),
    .c_rsp_valid(c_rsp_valid), .c_rsp_rdata(c_rsp_rdata),
    .irq_ctl(irq_ctl), .irq_host(irq_host)
  );

  int n_chk = 0, n_err = 0;
  logic [63:0] m_mb [8];
  logic [63:0] m_db [2];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] m_read(input logic [7:0] a);
    if (a >= 8'h50 && a <= 8'h57) return m_mb[a - 8'h50];
    if (a >= 8'h60 && a <= 8'h62) return m_db[0];
    if (a >= 8'h63 && a <= 8'h65) return m_db[1];
    return 64'h0;
  endfunction

  function automatic string a_tag(input logic [7:0] a);
    if (a >= 8'h50 && a <= 8'h57) return "R3";
    if (a == 8'h60 || a == 8'h63) return "R5";
    if (a >= 8'h60 && a <= 8'h65) return "R7";
    return "R8";
  endfunction

  // one bus cycle on both ports; entered and left at a falling edge
  task automatic cyc(input logic hv, input logic hw, input logic [7:0] ha, input logic [63:0] hd,
                     input logic cv, input logic cw, input logic [7:0] ca, input logic [63:0] cd,
                     input string t);
    logic [63:0] exp_h, exp_c, base, orm, andm;
    h_req_valid = hv; h_req_write = hw; h_req_addr = ha; h_req_wdata = hd;
    c_req_valid = cv; c_req_write = cw; c_req_addr = ca; c_req_wdata = cd;
    exp_h = m_read(ha);
    exp_c = m_read(ca);
    @(posedge clk);
    // model update
    if (hv && hw && ha >= 8'h50 && ha <= 8'h53) m_mb[ha - 8'h50] = hd;
    if (cv && cw && ca >= 8'h54 && ca <= 8'h57) m_mb[ca - 8'h50] = cd;
    for (int d = 0; d < 2; d++) begin
      base = m_db[d]; orm = 64'h0; andm = '1;
      if (hv && hw && ha == 8'h60 + 8'(3*d)) base = hd;
      if (cv && cw && ca == 8'h60 + 8'(3*d)) base = cd;
      if (hv && hw && ha == 8'h62 + 8'(3*d)) orm |= hd;
      if (cv && cw && ca == 8'h62 + 8'(3*d)) orm |= cd;
      if (hv && hw && ha == 8'h61 + 8'(3*d)) andm &= hd;
      if (cv && cw && ca == 8'h61 + 8'(3*d)) andm &= cd;
      m_db[d] = (base | orm) & andm;
    end
    @(negedge clk);
    chk("R2 host ready", {63'h0, h_req_ready}, 64'h1);
    chk("R2 ctl ready", {63'h0, c_req_ready}, 64'h1);
    chk("R2 host rsp_valid", {63'h0, h_rsp_valid}, {63'h0, hv && !hw});
    chk("R2 ctl rsp_valid", {63'h0, c_rsp_valid}, {63'h0, cv && !cw});
    if (hv && !hw) chk(t != "" ? t : a_tag(ha), h_rsp_rdata, exp_h);
    if (cv && !cw) chk(t != "" ? t : a_tag(ca), c_rsp_rdata, exp_c);
    chk("R9 irq_ctl", {63'h0, irq_ctl}, {63'h0, |m_db[0]});
    chk("R9 irq_host", {63'h0, irq_host}, {63'h0, |m_db[1]});
    h_req_valid = 0; c_req_valid = 0;
  endtask

  task automatic hrd(input logic [7:0] a, input string t);
    cyc(1, 0, a, 0, 0, 0, 0, 0, t);
  endtask
  task automatic crd(input logic [7:0] a, input string t);
    cyc(0, 0, 0, 0, 1, 0, a, 0, t);
  endtask
  task automatic hwr(input logic [7:0] a, input logic [63:0] d);
    cyc(1, 1, a, d, 0, 0, 0, 0, "");
  endtask
  task automatic cwr(input logic [7:0] a, input logic [63:0] d);
    cyc(0, 0, 0, 0, 1, 1, a, d, "");
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 8; i++) m_mb[i] = 64'h0;
    m_db[0] = 64'h0; m_db[1] = 64'h0;
    repeat (3) @(negedge clk);
    chk("R1 irq_ctl at reset", {63'h0, irq_ctl}, 64'h0);
    chk("R1 irq_host at reset", {63'h0, irq_host}, 64'h0);
    chk("R1 rsp_valid at reset", {62'h0, h_rsp_valid, c_rsp_valid}, 64'h0);
    rst_n = 1;
    @(negedge clk);

    // R1: every address reads zero after reset, from both sides
    for (int i = 0; i < 256; i++) cyc(1, 0, 8'(i), 0, 1, 0, 8'(255 - i), 0, "R1");

    // both sides write every address at once, then read all back
    for (int i = 0; i < 256; i++)
      cyc(1, 1, 8'(i), 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15),
          1, 1, 8'(i), 64'hF0E1_D2C3_B4A5_9687 + (64'(i) << 17), "");
    for (int i = 0; i < 256; i++) cyc(1, 0, 8'(i), 0, 1, 0, 8'(i ^ 8'h05), 0, "");

    // R4: foreign-half writes ignored
    hwr(8'h56, 64'hDEAD_BEEF_0000_0001);
    crd(8'h56, "R4");
    cwr(8'h51, 64'hDEAD_BEEF_0000_0002);
    hrd(8'h51, "R4");
    hwr(8'h52, 64'h1111_2222_3333_4444);
    crd(8'h52, "R4");

    // clear doorbells
    hwr(8'h60, 64'h0);
    cwr(8'h63, 64'h0);
    // R6: bit 0 is the MSB
    hwr(8'h62, 64'h8000_0000_0000_0000);
    crd(8'h60, "R6");
    crd(8'h61, "R7");
    repeat (3) cyc(0, 0, 0, 0, 0, 0, 0, 0, "");
    // R10: host sets bit 1 while controller clears bit 0 at the same edge
    cyc(1, 1, 8'h62, 64'h4000_0000_0000_0000, 1, 1, 8'h61, 64'h7FFF_FFFF_FFFF_FFFF, "");
    crd(8'h60, "R10");
    // R10: OR and AND of the same bit at once, clear wins
    cyc(1, 1, 8'h62, 64'h0000_0000_0000_00FF, 1, 1, 8'h61, 64'hFFFF_FFFF_FFFF_FF0F, "");
    hrd(8'h62, "R10");
    cwr(8'h61, 64'h0);
    crd(8'h60, "R9");
    // controller sets bits 0..2 toward the host
    cwr(8'h65, 64'h2000_0000_0000_0000);
    hrd(8'h63, "R6");
    hwr(8'h64, 64'h7FFF_FFFF_FFFF_FFFF);
    hrd(8'h64, "R6");
    cwr(8'h65, 64'hC000_0000_0000_0000);
    hwr(8'h64, 64'h7FFF_FFFF_FFFF_FFFF);
    hrd(8'h65, "R6");
    hwr(8'h64, 64'h0);
    // R10: both plain writes, controller wins; plain then OR
    cyc(1, 1, 8'h63, 64'hAAAA_0000_0000_0000, 1, 1, 8'h63, 64'h5555_0000_0000_0000, "");
    hrd(8'h63, "R10");
    cyc(1, 1, 8'h60, 64'h0000_0000_0F00_0000, 1, 1, 8'h62, 64'h0000_0000_0000_0003, "");
    crd(8'h60, "R10");
    // R8: unmapped write leaves everything intact
    hwr(8'h66, '1);
    cwr(8'h4F, '1);
    hrd(8'h66, "R8");
    crd(8'h60, "R8");
    hrd(8'h57, "R8");

    // pseudo-random traffic on both sides around the map
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r1, r2;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r1 = lfsr * 32'h0019_660D + 32'h3C6E_F35F;
      r2 = r1 * 32'h0019_660D + 32'h3C6E_F35F;
      cyc(r1[0], r1[1], 8'h4C + 8'(r1[15:8] % 8'd28), {r1, r2},
          r1[2], r1[3], 8'h4C + 8'(r2[15:8] % 8'd28), {r2 ^ 32'h5A5A_5A5A, r1 >> 3}, "");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule